// File: doc/BRIEF.md
# Self-Test Data-RAM Access Adapter

This block connects a memory self-test engine to the data RAM of a 16-way set-associative cache whose size is chosen at run time. Each cycle the engine presents an address, 64-bit write data, a chip-enable, a write flag and a 3-bit read-control code. The adapter turns the address into a RAM index that depends on the configured cache size and drives the RAM's enable, write strobe, index and write data in the same cycle.

Read data comes back from the RAM after a configurable latency of one to eight cycles. The adapter follows each read with a valid flag that matches that latency. It then passes the data through two more register stages and presents it as a one-cycle `rd_valid` beat. Each returning beat can also be stored in one 64-bit lane of a 256-bit line buffer, which the tester reads directly.

The return side has no ready signal. Reads can be issued back to back, one per cycle. Every beat appears exactly once, at a fixed cycle, and the tester must take it in that cycle. `cfg_size` and `cfg_lat` may only change while no read is in flight.

Top module: `bist_dram_adapter`

## Requirements
- R1: `ram_idx` equals `tst_addr[19:16]` placed directly above `tst_addr[10+S:2]`, where S is the effective size code (0 = 256 KB up to 5 = 8 MB), so the index is 13+S bits wide.
- R2: Every `ram_idx` bit at or above position 13+S is zero.
- R3: `cfg_size` codes 6 and 7 map the index exactly as code 5 does.
- R4: `ram_ce` follows `tst_ce[0]` in the same cycle. `tst_ce[1]` has no effect: with `tst_ce` = 2'b10 there is no RAM access and no read return.
- R5: `ram_we` is high only when `tst_ce[0]` and `tst_we` are both high, and `ram_wdata` equals `tst_wdata` unchanged.
- R6: A read is a cycle with `tst_ce[0]`=1 and `tst_we`=0. With L = `cfg_lat`+1 (RAM latency 1..8), `rd_valid` is high for exactly one cycle, L+2 cycles after the read's request cycle. At all other times it is low.
- R7: On that beat, `rd_data` carries the RAM word stored at the read's index. Back-to-back reads each return their own word, in consecutive cycles.
- R8: `tst_rdctl` is sampled with the read. If bit 2 is 1, the returned word replaces lane `tst_rdctl[1:0]` of `line_buf` in the same cycle that `rd_valid` is high, where lane k occupies bits [64k+63:64k]. Other lanes keep their value. If bit 2 is 0, `line_buf` is left unchanged.
- R9: While `rst_n` is low, `rd_valid` is 0 and `rd_data` and `line_buf` are all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_size | input | 3 | Cache size code, 0 = 256 KB ... 5 = 8 MB |
| cfg_lat | input | 3 | RAM read latency minus one |
| tst_addr | input | 20 | Test address, way in [19:16] |
| tst_wdata | input | 64 | Test write data |
| tst_ce | input | 2 | Test chip enable, only bit 0 used |
| tst_we | input | 1 | Write when high, read when low |
| tst_rdctl | input | 3 | Bit 2 capture, bits 1:0 line-buffer lane |
| ram_ce | output | 1 | Data RAM chip enable |
| ram_we | output | 1 | Data RAM write strobe |
| ram_idx | output | 18 | Data RAM index |
| ram_wdata | output | 64 | Data RAM write data |
| ram_rdata | input | 64 | Data RAM read data |
| rd_valid | output | 1 | Return beat marker |
| rd_data | output | 64 | Returned read word |
| line_buf | output | 256 | Captured read line, four 64-bit lanes |

## Verification
The RAM-side outputs (`ram_ce`, `ram_we`, `ram_idx`, `ram_wdata`) are combinational. The bench drives them on the falling edge and compares them 1 ns later in the same cycle, sweeping all eight size codes, all sixteen ways and a set of set-field patterns.

Each read returns its beat on the (L+2)-th falling edge after it was driven. The bench files the expected word, capture flag and lane into a ring slot indexed by falling-edge count. On every falling edge it then checks either the expected beat and the line buffer, or that `rd_valid` is low. This is repeated for all eight latencies with back-to-back reads, gaps and ignored enables.

// File: rtl/bdra_pkg.sv
`timescale 1ns/1ps
package bdra_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = $clog2(LANES);
  localparam int CTL_W  = LANE_W + 1;

  typedef struct packed {
    logic              cap;
    logic [LANE_W-1:0] lane;
  } rd_ctl_t;
endpackage

// File: rtl/bdra_index_map.sv
`timescale 1ns/1ps
module bdra_index_map #(
  parameter int ADDR_W     = 20,
  parameter int WAY_W      = 4,
  parameter int MIN_SET_W  = 9,
  parameter int SIZE_STEPS = 6,
  parameter int SZ_W       = 3,
  localparam int IDX_W     = WAY_W + MIN_SET_W + SIZE_STEPS - 1,
  localparam int SET_LO    = ADDR_W - IDX_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SZ_W-1:0]   size,
  output logic [IDX_W-1:0]  idx
);
  // one candidate index per cache size, way field above the set slice
  logic [IDX_W-1:0] cand [SIZE_STEPS];

  for (genvar s = 0; s < SIZE_STEPS; s++) begin : g_size
    localparam int SW = MIN_SET_W + s;
    assign cand[s] = IDX_W'({addr[ADDR_W-1 -: WAY_W], addr[SET_LO+SW-1:SET_LO]});
  end

  logic [SZ_W-1:0] sel;
  assign sel = (size >= SZ_W'(SIZE_STEPS - 1)) ? SZ_W'(SIZE_STEPS - 1) : size;
  assign idx = cand[sel];

  logic unused_low_bits;
  assign unused_low_bits = ^addr[SET_LO-1:0];
endmodule

// File: rtl/bdra_lat_pipe.sv
`timescale 1ns/1ps
module bdra_lat_pipe #(
  parameter int DATA_W  = 64,
  parameter int MAX_LAT = 8,
  parameter int LAT_W   = 3,
  parameter int CTL_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LAT_W-1:0]  cfg_lat,
  input  logic              issue,
  input  logic [CTL_W-1:0]  issue_ctl,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              a_vld,
  output logic [CTL_W-1:0]  a_ctl,
  output logic [DATA_W-1:0] a_data
);
  logic [MAX_LAT-1:0] vsr;
  logic [CTL_W-1:0]   csr [MAX_LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vsr <= '0;
      for (int k = 0; k < MAX_LAT; k++) csr[k] <= '0;
    end else begin
      vsr    <= {vsr[MAX_LAT-2:0], issue};
      csr[0] <= issue_ctl;
      for (int k = 1; k < MAX_LAT; k++) csr[k] <= csr[k-1];
    end
  end

  // tap where the RAM word for the marked read is on ram_rdata
  logic             tap_v;
  logic [CTL_W-1:0] tap_c;
  assign tap_v = vsr[cfg_lat];
  assign tap_c = csr[cfg_lat];

  // first of the two fixed return registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_vld  <= 1'b0;
      a_ctl  <= '0;
      a_data <= '0;
    end else begin
      a_vld <= tap_v;
      if (tap_v) begin
        a_ctl  <= tap_c;
        a_data <= ram_rdata;
      end
    end
  end
endmodule

// File: rtl/bdra_line_buf.sv
`timescale 1ns/1ps
module bdra_line_buf #(
  parameter int DATA_W  = 64,
  parameter int LANES   = 4,
  parameter int LANE_W  = 2,
  localparam int LINE_W = LANES * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_vld,
  input  logic [LANE_W-1:0] cap_lane,
  input  logic [DATA_W-1:0] cap_data,
  output logic [LINE_W-1:0] line
);
  logic [DATA_W-1:0] lane_q [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   lane_q[g] <= '0;
      else if (cap_vld && cap_lane == LANE_W'(g))   lane_q[g] <= cap_data;
    end
    assign line[g*DATA_W +: DATA_W] = lane_q[g];
  end
endmodule

// File: rtl/bist_dram_adapter.sv
`timescale 1ns/1ps
module bist_dram_adapter #(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 64,
  parameter int WAY_W      = 4,
  parameter int MIN_SET_W  = 9,
  parameter int SIZE_STEPS = 6,
  parameter int MAX_LAT    = 8,
  localparam int IDX_W     = WAY_W + MIN_SET_W + SIZE_STEPS - 1,
  localparam int SZ_W      = $clog2(SIZE_STEPS),
  localparam int LAT_W     = $clog2(MAX_LAT),
  localparam int LINE_W    = bdra_pkg::LANES * DATA_W,
  localparam int CTL_W     = bdra_pkg::CTL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SZ_W-1:0]   cfg_size,
  input  logic [LAT_W-1:0]  cfg_lat,
  input  logic [ADDR_W-1:0] tst_addr,
  input  logic [DATA_W-1:0] tst_wdata,
  input  logic [1:0]        tst_ce,
  input  logic              tst_we,
  input  logic [CTL_W-1:0]  tst_rdctl,
  output logic              ram_ce,
  output logic              ram_we,
  output logic [IDX_W-1:0]  ram_idx,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [LINE_W-1:0] line_buf
);
  import bdra_pkg::*;

  // request side: straight to the RAM
  logic issue;
  assign ram_ce    = tst_ce[0];
  assign ram_we    = tst_ce[0] & tst_we;
  assign ram_wdata = tst_wdata;
  assign issue     = tst_ce[0] & ~tst_we;

  logic unused_ce_hi;
  assign unused_ce_hi = tst_ce[1];

  bdra_index_map #(
    .ADDR_W(ADDR_W), .WAY_W(WAY_W), .MIN_SET_W(MIN_SET_W),
    .SIZE_STEPS(SIZE_STEPS), .SZ_W(SZ_W)
  ) u_map (
    .addr(tst_addr), .size(cfg_size), .idx(ram_idx)
  );

  // return side: latency tap plus two fixed stages
  logic              a_vld;
  logic [CTL_W-1:0]  a_ctl;
  logic [DATA_W-1:0] a_data;
  rd_ctl_t           a_ctl_s;

  bdra_lat_pipe #(
    .DATA_W(DATA_W), .MAX_LAT(MAX_LAT), .LAT_W(LAT_W), .CTL_W(CTL_W)
  ) u_pipe (
    .clk(clk), .rst_n(rst_n), .cfg_lat(cfg_lat),
    .issue(issue), .issue_ctl(tst_rdctl), .ram_rdata(ram_rdata),
    .a_vld(a_vld), .a_ctl(a_ctl), .a_data(a_data)
  );

  assign a_ctl_s = rd_ctl_t'(a_ctl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= a_vld;
      if (a_vld) rd_data <= a_data;
    end
  end

  bdra_line_buf #(
    .DATA_W(DATA_W), .LANES(LANES), .LANE_W(LANE_W)
  ) u_lbuf (
    .clk(clk), .rst_n(rst_n),
    .cap_vld(a_vld & a_ctl_s.cap), .cap_lane(a_ctl_s.lane),
    .cap_data(a_data), .line(line_buf)
  );
endmodule

// File: rtl/bdra_checker.sv
`timescale 1ns/1ps
module bdra_checker #(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 64,
  parameter int WAY_W      = 4,
  parameter int MIN_SET_W  = 9,
  parameter int SIZE_STEPS = 6,
  parameter int MAX_LAT    = 8,
  localparam int IDX_W     = WAY_W + MIN_SET_W + SIZE_STEPS - 1,
  localparam int SZ_W      = $clog2(SIZE_STEPS),
  localparam int LAT_W     = $clog2(MAX_LAT),
  localparam int LINE_W    = 4 * DATA_W,
  localparam int SET_LO    = ADDR_W - IDX_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SZ_W-1:0]   cfg_size,
  input logic [LAT_W-1:0]  cfg_lat,
  input logic [ADDR_W-1:0] tst_addr,
  input logic [1:0]        tst_ce,
  input logic              tst_we,
  input logic              ram_ce,
  input logic              ram_we,
  input logic [IDX_W-1:0]  ram_idx,
  input logic              rd_valid,
  input logic [LINE_W-1:0] line_buf
);
  int unsigned      eff_sz;
  int unsigned      set_w;
  logic [IDX_W-1:0] set_mask;
  assign eff_sz   = (int'(cfg_size) > SIZE_STEPS - 1) ? SIZE_STEPS - 1 : int'(cfg_size);
  assign set_w    = MIN_SET_W + eff_sz;
  assign set_mask = (IDX_W'(1) << set_w) - IDX_W'(1);

  // independent record of issued reads
  logic [MAX_LAT+1:0] hist;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist <= '0;
    else        hist <= {hist[MAX_LAT:0], tst_ce[0] & ~tst_we};
  end

  p_idx_way_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ram_ce |-> ((ram_idx >> set_w) == IDX_W'(tst_addr[ADDR_W-1 -: WAY_W])));

  p_idx_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ram_ce |-> (((ram_idx ^ IDX_W'(tst_addr >> SET_LO)) & set_mask) == '0));

  p_ce_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tst_ce[0] |-> (!ram_ce && !ram_we));

  p_ret_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid == hist[int'(cfg_lat) + 2]);

  p_line_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> $stable(line_buf));
endmodule

bind bist_dram_adapter bdra_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAY_W(WAY_W),
  .MIN_SET_W(MIN_SET_W), .SIZE_STEPS(SIZE_STEPS), .MAX_LAT(MAX_LAT)
) u_bdra_chk (
  .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .cfg_lat(cfg_lat),
  .tst_addr(tst_addr), .tst_ce(tst_ce), .tst_we(tst_we),
  .ram_ce(ram_ce), .ram_we(ram_we), .ram_idx(ram_idx),
  .rd_valid(rd_valid), .line_buf(line_buf)
);

// File: tb/bist_dram_adapter_bench.sv
`timescale 1ns/1ps
module bist_dram_adapter_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   cfg_size = '0;
  logic [2:0]   cfg_lat = '0;
  logic [19:0]  tst_addr = '0;
  logic [63:0]  tst_wdata = '0;
  logic [1:0]   tst_ce = '0;
  logic         tst_we = 1'b0;
  logic [2:0]   tst_rdctl = '0;
  logic         ram_ce, ram_we;
  logic [17:0]  ram_idx;
  logic [63:0]  ram_wdata, ram_rdata;
  logic         rd_valid;
  logic [63:0]  rd_data;
  logic [255:0] line_buf;

  always #5 clk = ~clk;

  bist_dram_adapter u_bist_dram_adapter (
    .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .cfg_lat(cfg_lat),
    .tst_addr(tst_addr), .tst_wdata(tst_wdata), .tst_ce(tst_ce),
    .tst_we(tst_we), .tst_rdctl(tst_rdctl), .ram_ce(ram_ce), .ram_we(ram_we),
    .ram_idx(ram_idx), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .line_buf(line_buf)
  );

  // behavioural RAM with 1..8 cycle read latency
  logic [63:0] mem [int unsigned];
  logic [63:0] q [8];
  always @(posedge clk) begin
    if (ram_ce && ram_we) mem[int'(ram_idx)] = ram_wdata;
    q[0] <= (ram_ce && !ram_we && mem.exists(int'(ram_idx))) ? mem[int'(ram_idx)] : 64'd0;
    for (int k = 1; k < 8; k++) q[k] <= q[k-1];
  end
  assign ram_rdata = q[cfg_lat];

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int cur_lat = 1;
  int cur_sz = 0;

  logic [63:0]  ref_mem [int unsigned];
  logic [255:0] lb_ref = '0;
  bit           exp_v [32];
  logic [63:0]  exp_d [32];
  bit           exp_c [32];
  int           exp_l [32];

  task automatic chk(input bit ok, input string tag, input logic [255:0] act,
                     input logic [255:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  function automatic int unsigned ref_idx(input logic [19:0] a, input int sz);
    int s;
    int sw;
    s  = (sz > 5) ? 5 : sz;
    sw = 9 + s;
    return (int'(a[19:16]) << sw) | ((int'(a) >> 2) & ((1 << sw) - 1));
  endfunction

  function automatic logic [19:0] waddr(input int i);
    return {4'(i * 2 + 1), 16'(i * 148 + 20)};
  endfunction

  task automatic step(input logic [1:0] ce, input logic we, input logic [19:0] a,
                      input logic [63:0] wd, input logic [2:0] ctl);
    int slot;
    int ns;
    @(negedge clk);
    cyc++;
    slot = cyc % 32;
    if (exp_v[slot]) begin
      chk(rd_valid === 1'b1, "R6 beat due", 256'(rd_valid), 256'(1));
      chk(rd_data === exp_d[slot], "R7 word", 256'(rd_data), 256'(exp_d[slot]));
      if (exp_c[slot]) begin
        lb_ref[exp_l[slot]*64 +: 64] = exp_d[slot];
        chk(line_buf === lb_ref, "R8 lane capture", line_buf, lb_ref);
      end else begin
        chk(line_buf === lb_ref, "R8 capture off", line_buf, lb_ref);
      end
      exp_v[slot] = 1'b0;
    end else begin
      chk(rd_valid === 1'b0, "R6 no beat", 256'(rd_valid), 256'(0));
    end
    tst_ce = ce; tst_we = we; tst_addr = a; tst_wdata = wd; tst_rdctl = ctl;
    if (ce[0] && we) ref_mem[ref_idx(a, cur_sz)] = wd;
    if (ce[0] && !we) begin
      ns = (cyc + cur_lat + 2) % 32;
      exp_v[ns] = 1'b1;
      exp_d[ns] = ref_mem.exists(ref_idx(a, cur_sz)) ? ref_mem[ref_idx(a, cur_sz)] : 64'd0;
      exp_c[ns] = ctl[2];
      exp_l[ns] = int'(ctl[1:0]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 32; k++) exp_v[k] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk(rd_valid === 1'b0, "R9 valid", 256'(rd_valid), 256'(0));
    chk(rd_data === 64'd0, "R9 data", 256'(rd_data), 256'(0));
    chk(line_buf === 256'd0, "R9 line", line_buf, 256'd0);
    chk(ram_ce === 1'b0, "R4 idle ce", 256'(ram_ce), 256'(0));
    rst_n = 1'b1;

    // sweep of the request side: index map, enables, write data
    for (int sz = 0; sz < 8; sz++) begin
      cfg_size = 3'(sz);
      for (int way = 0; way < 16; way++) begin
        for (int j = 0; j < 32; j++) begin
          logic [15:0] lo;
          int unsigned sw;
          string tag;
          lo = (j < 16) ? 16'(1 << j) : ((j == 16) ? 16'hFFFF : 16'(j * 16'h9E37));
          @(negedge clk);
          tst_addr  = {4'(way), lo};
          tst_ce    = 2'(j);
          tst_we    = j[2];
          tst_wdata = {32'(way * 977 + j), 32'(sz * 31 + j)};
          #1;
          sw  = (sz > 5) ? 14 : 9 + sz;
          tag = (sz > 5) ? "R3 clamp index" : "R1 index";
          chk(int'(ram_idx) == ref_idx(tst_addr, sz), tag, 256'(ram_idx),
              256'(ref_idx(tst_addr, sz)));
          chk((int'(ram_idx) >> (sw + 4)) == 0, "R2 upper zero", 256'(ram_idx), 256'(0));
          chk(ram_ce === tst_ce[0], "R4 ce bit0", 256'(ram_ce), 256'(tst_ce[0]));
          chk(ram_we === (tst_ce[0] & tst_we), "R5 we", 256'(ram_we),
              256'(tst_ce[0] & tst_we));
          chk(ram_wdata === tst_wdata, "R5 wdata", 256'(ram_wdata), 256'(tst_wdata));
        end
      end
    end
    @(negedge clk);
    tst_ce = '0; tst_we = 1'b0;
    repeat (12) @(negedge clk);
    cyc = 0;

    // read return across every latency
    for (int lat = 1; lat <= 8; lat++) begin
      cur_lat  = lat;
      cur_sz   = (lat + 2) % 8;
      cfg_lat  = 3'(lat - 1);
      cfg_size = 3'(cur_sz);
      for (int i = 0; i < 8; i++)
        step(2'b01, 1'b1, waddr(i), {32'(lat), 32'(i)} ^ 64'hA5C3_0F96_5A3C_F069, 3'd0);
      for (int r = 0; r < 12; r++) begin
        if (r == 5)      step(2'b00, 1'b0, 20'd0, 64'd0, 3'd0);
        else if (r == 7) step(2'b10, 1'b0, waddr(3), 64'd0, 3'b111); // R4 bit1 only
        else             step(2'b01, 1'b0, waddr((r * 3) % 8), 64'd0,
                              {(r % 3) != 0, 2'(r)});
      end
      for (int d = 0; d < 14; d++) step(2'b00, 1'b0, 20'd0, 64'd0, 3'd0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule